// File: doc/BRIEF.md
# Paired Transmit/Receive FIFO with Fill-Level Interrupts

This block holds the data buffering of a serial peripheral: one FIFO feeding the transmit shifter and one FIFO collecting words from the receive shifter. Both FIFOs share the same fixed byte budget. The number of words each one can hold therefore depends on the selected word width. A narrow word gives a deep FIFO and a wide word gives a shallow one.

Each side reports how many words it holds. Each side also drives one level interrupt, and a 2-bit mode input picks the fill condition that drives it. Errors are kept in sticky flags: a receive word that arrives with no room sets one flag, and a transmit pop that finds nothing to send in framed operation sets another. A register front end and a shifter sit around the block and drive its push, pop and configuration inputs.

Top module: `sfifo_pair`

## Requirements
- R1: Each FIFO holds FIFO_BYTES (default 16) bytes. Its depth in words is 16 when `word_size`=0 (8-bit), 8 when `word_size`=1 (16-bit), and 4 when `word_size` is 2 or 3 (32-bit). The fill level never exceeds that depth.
- R2: Words leave each FIFO in the order they entered. The pop data port shows the oldest word whenever the level is nonzero. Stored words are zero above the active word width (bits 7:0 kept for 8-bit, bits 15:0 for 16-bit, all 32 bits for 32-bit).
- R3: A push into a full FIFO with no pop in the same cycle is discarded, and the level and contents stay unchanged. On the receive side this sets the sticky `rx_overflow` flag.
- R4: A pop from an empty FIFO has no effect on that FIFO's level or contents.
- R5: A transmit pop from an empty FIFO sets the sticky `tx_underrun` flag only while `framed_mode` is 1. With `framed_mode` at 0 it leaves the flag unchanged.
- R6: `err_clr` clears both sticky flags in the next cycle. When an error event happens in the same cycle as `err_clr`, the flag is set.
- R7: Any change of `word_size` flushes both FIFOs, so both levels read 0 one cycle later. A push or pop in that same cycle is ignored. The sticky flags are not changed by the flush.
- R8: `rx_irq` depends on `rx_irq_mode` as follows: 0 = level is zero; 1 = level is nonzero; 2 = twice the level is at least the depth; 3 = level equals the depth.
- R9: `tx_irq` depends on `tx_irq_mode` as follows: 0 = level is zero and `tx_shift_busy` is 0; 1 = level is zero; 2 = twice the free slots are at least the depth; 3 = level is below the depth.
- R10: Levels are 5-bit counts that rise by one on an accepted push and fall by one on an accepted pop. A push and a pop in the same cycle on a non-empty FIFO leave the level unchanged, even when the FIFO is full.
- R11: Synchronous active-low reset empties both FIFOs, clears both sticky flags and selects the 8-bit word size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_size | input | 2 | Word width select: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| framed_mode | input | 1 | Framed operation; enables underrun detection |
| err_clr | input | 1 | Clears both sticky error flags |
| tx_push | input | 1 | Write one word into the transmit FIFO |
| tx_push_data | input | 32 | Word to write into the transmit FIFO |
| tx_pop | input | 1 | Shifter takes the oldest transmit word |
| tx_pop_data | output | 32 | Oldest transmit word |
| tx_level | output | 5 | Transmit FIFO word count |
| tx_irq_mode | input | 2 | Transmit interrupt condition select |
| tx_shift_busy | input | 1 | Transmit shifter still holds a word |
| tx_irq | output | 1 | Transmit level interrupt |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_push | input | 1 | Shifter delivers one received word |
| rx_push_data | input | 32 | Received word |
| rx_pop | input | 1 | Read the oldest receive word |
| rx_pop_data | output | 32 | Oldest receive word |
| rx_level | output | 5 | Receive FIFO word count |
| rx_irq_mode | input | 2 | Receive interrupt condition select |
| rx_irq | output | 1 | Receive level interrupt |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
The bench overfills each FIFO at every word size. A design with a fixed depth would then report the wrong level, and a design that overwrites on overflow would return a newer word where the oldest one belongs. The bench changes the word size while a FIFO holds data. A design that did not flush would keep stale words and a level above the new depth. The bench also drives push and pop together on a full FIFO, and drives a pop into an empty transmit FIFO with framing on and with framing off. An error at either point would show up as a wrongly raised underrun or overflow flag, or as a level that drifts. Random traffic sweeps all eight interrupt conditions. At the half-full point and the half-empty point, a design that got the off-by-one wrong would move the interrupt one word early or late.

// File: rtl/sfifo_pkg.sv
// Package: shared encodings and depth arithmetic for the FIFO pair.
// Assumes word widths of 8, 16 and 32 bits; code 3 behaves as 32-bit.
package sfifo_pkg;

    typedef enum logic [1:0] {
        WSZ_8   = 2'd0,
        WSZ_16  = 2'd1,
        WSZ_32  = 2'd2,
        WSZ_32B = 2'd3
    } wsize_e;

    // Bytes per word for a word-size code.
    function automatic int unsigned word_bytes(input logic [1:0] ws);
        case (ws)
            WSZ_8:   return 1;
            WSZ_16:  return 2;
            default: return 4;
        endcase
    endfunction

    // Words that fit in the byte budget, rounded up.
    function automatic int unsigned depth_for(input int unsigned fifo_bytes,
                                              input logic [1:0] ws);
        int unsigned wb;
        wb = word_bytes(ws);
        return (fifo_bytes + wb - 1) / wb;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
// Module: one circular FIFO whose usable depth is set at run time.
// Assumes the depth input changes only together with a flush pulse,
// and depth never exceeds MAX_DEPTH. A push into a full FIFO is
// accepted only when a pop frees a slot in the same cycle.
module sfifo_store #(
    parameter int DATA_W    = 32,
    parameter int MAX_DEPTH = 16,
    localparam int LVL_W    = $clog2(MAX_DEPTH + 1),
    localparam int PTR_W    = $clog2(MAX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [LVL_W-1:0]  depth,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [LVL_W-1:0]  level,
    output logic              push_drop,
    output logic              pop_empty
);

    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              pop_ok, push_ok;

    // Advance a pointer, wrapping at the active depth.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                               input logic [LVL_W-1:0] d);
        if (LVL_W'(p) == d - LVL_W'(1)) return '0;
        return p + PTR_W'(1);
    endfunction

    // Accept rules: pop needs data, push needs room or a same-cycle pop.
    always_comb begin
        pop_ok    = pop && (level != '0) && !flush;
        push_ok   = push && ((level != depth) || pop_ok) && !flush;
        push_drop = push && !push_ok && !flush;
        pop_empty = pop && !pop_ok && !flush;
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and level bookkeeping with reset and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr, depth);
            if (pop_ok)  rd_ptr <= bump(rd_ptr, depth);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    // Head of the queue is always presented.
    assign pop_data = mem[rd_ptr];

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= depth);
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == depth && !flush) |=> $stable(level));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && level == '0 && !flush) |=> level == '0);
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0);
    p_pushpop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && level != '0 && !flush) |=> $stable(level));

endmodule

// File: rtl/sfifo_irq_sel.sv
// Module: selects one of four fill-level conditions as a level interrupt.
// IS_TX picks the transmit set (emptiness-based) or the receive set
// (fullness-based). aux_idle qualifies the "fully drained" condition;
// tie it to 1 where no shifter state applies.
module sfifo_irq_sel #(
    parameter int LVL_W = 5,
    parameter bit IS_TX = 1'b0
) (
    input  logic [1:0]       mode,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] depth,
    input  logic             aux_idle,
    output logic             irq
);

    logic [LVL_W:0] lvl_x2, free_x2, dep_w;

    // Widened operands for the half-way comparisons.
    always_comb begin
        dep_w   = {1'b0, depth};
        lvl_x2  = {level, 1'b0};
        free_x2 = {depth - level, 1'b0};
    end

    generate
        if (IS_TX) begin : g_tx
            // Transmit side: conditions on empty slots.
            always_comb begin
                case (mode)
                    2'd0:    irq = (level == '0) && aux_idle;
                    2'd1:    irq = (level == '0);
                    2'd2:    irq = (free_x2 >= dep_w);
                    default: irq = (level < depth);
                endcase
            end
        end else begin : g_rx
            // Receive side: conditions on stored words.
            always_comb begin
                case (mode)
                    2'd0:    irq = (level == '0) && aux_idle;
                    2'd1:    irq = (level != '0);
                    2'd2:    irq = (lvl_x2 >= dep_w);
                    default: irq = (level == depth);
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/sfifo_pair.sv
// Module: transmit and receive FIFOs sharing a byte budget, with
// word-size dependent depth, level interrupts and sticky error flags.
// Assumes word_size is held steady during traffic; any change flushes.
module sfifo_pair #(
    parameter int DATA_W     = 32,
    parameter int FIFO_BYTES = 16,
    localparam int MAX_DEPTH = FIFO_BYTES,
    localparam int LVL_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        word_size,
    input  logic              framed_mode,
    input  logic              err_clr,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic [LVL_W-1:0]  tx_level,
    input  logic [1:0]        tx_irq_mode,
    input  logic              tx_shift_busy,
    output logic              tx_irq,
    output logic              tx_underrun,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic [LVL_W-1:0]  rx_level,
    input  logic [1:0]        rx_irq_mode,
    output logic              rx_irq,
    output logic              rx_overflow
);
    import sfifo_pkg::*;

    logic [1:0]        ws_q;
    logic              flush;
    logic [LVL_W-1:0]  depth;
    logic [DATA_W-1:0] wmask;
    logic              tx_drop, tx_empty_pop, rx_drop, rx_empty_pop;

    // Track the active word size; a mismatch triggers the flush.
    always_ff @(posedge clk) begin
        if (!rst_n) ws_q <= WSZ_8;
        else        ws_q <= word_size;
    end

    // Depth and data mask derived from the active word size.
    always_comb begin
        flush = (word_size != ws_q);
        depth = LVL_W'(depth_for(FIFO_BYTES, ws_q));
        for (int i = 0; i < DATA_W; i++)
            wmask[i] = (i < 8 * int'(word_bytes(ws_q)));
    end

    sfifo_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_tx_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .depth(depth),
        .push(tx_push), .push_data(tx_push_data & wmask),
        .pop(tx_pop), .pop_data(tx_pop_data), .level(tx_level),
        .push_drop(tx_drop), .pop_empty(tx_empty_pop)
    );

    sfifo_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_rx_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .depth(depth),
        .push(rx_push), .push_data(rx_push_data & wmask),
        .pop(rx_pop), .pop_data(rx_pop_data), .level(rx_level),
        .push_drop(rx_drop), .pop_empty(rx_empty_pop)
    );

    sfifo_irq_sel #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_irq (
        .mode(tx_irq_mode), .level(tx_level), .depth(depth),
        .aux_idle(!tx_shift_busy), .irq(tx_irq)
    );

    sfifo_irq_sel #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_irq (
        .mode(rx_irq_mode), .level(rx_level), .depth(depth),
        .aux_idle(1'b1), .irq(rx_irq)
    );

    // Sticky receive overflow; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_overflow <= 1'b0;
        else if (rx_drop) rx_overflow <= 1'b1;
        else if (err_clr) rx_overflow <= 1'b0;
    end

    // Sticky transmit underrun, armed only in framed operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tx_underrun <= 1'b0;
        else if (tx_empty_pop && framed_mode) tx_underrun <= 1'b1;
        else if (err_clr)                     tx_underrun <= 1'b0;
    end

    // Receive empty-pop and transmit full-push raise no flag.
    logic unused_ok;
    assign unused_ok = rx_empty_pop ^ tx_drop;

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overflow && !err_clr) |=> rx_overflow);
    p_unframed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!framed_mode && !tx_underrun) |=> !tx_underrun);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !rx_push) |=> !rx_overflow);
    p_wsize_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_size != ws_q) |=> (tx_level == '0 && rx_level == '0));

endmodule

// File: tb/sfifo_pair_tb.sv
`timescale 1ns/1ps
module sfifo_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  word_size;
    logic        framed_mode, err_clr;
    logic        tx_push, tx_pop, tx_shift_busy, rx_push, rx_pop;
    logic [31:0] tx_push_data, rx_push_data;
    logic [1:0]  tx_irq_mode, rx_irq_mode;
    logic [31:0] tx_pop_data, rx_pop_data;
    logic [4:0]  tx_level, rx_level;
    logic        tx_irq, tx_underrun, rx_irq, rx_overflow;

    always #2 clk = ~clk;

    sfifo_pair u_dut (
        .clk(clk), .rst_n(rst_n), .word_size(word_size),
        .framed_mode(framed_mode), .err_clr(err_clr),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_level(tx_level),
        .tx_irq_mode(tx_irq_mode), .tx_shift_busy(tx_shift_busy),
        .tx_irq(tx_irq), .tx_underrun(tx_underrun),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_level(rx_level),
        .rx_irq_mode(rx_irq_mode), .rx_irq(rx_irq), .rx_overflow(rx_overflow)
    );

    // Reference model state
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [1:0]  m_ws;
    bit          m_ovf, m_ur, live;
    int          n_checks = 0;
    int          n_fail   = 0;

    function automatic int mdepth(input logic [1:0] ws);
        return (ws == 2'd0) ? 16 : (ws == 2'd1) ? 8 : 4;
    endfunction

    function automatic logic [31:0] mmask(input logic [1:0] ws);
        return (ws == 2'd0) ? 32'hFF : (ws == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update on each rising edge, from the inputs held since the last one.
    always @(posedge clk) begin
        bit t_pop_ok, r_pop_ok, t_push_ok, r_push_ok, ovf_evt, ur_evt;
        int d;
        live = 1'b1;
        if (!rst_n) begin
            txq.delete(); rxq.delete(); m_ws = 2'd0; m_ovf = 0; m_ur = 0;
        end else begin
            ovf_evt = 0; ur_evt = 0;
            if (word_size != m_ws) begin
                txq.delete(); rxq.delete(); m_ws = word_size;
            end else begin
                d = mdepth(m_ws);
                t_pop_ok  = tx_pop && txq.size() > 0;
                r_pop_ok  = rx_pop && rxq.size() > 0;
                t_push_ok = tx_push && (txq.size() < d || t_pop_ok);
                r_push_ok = rx_push && (rxq.size() < d || r_pop_ok);
                ovf_evt   = rx_push && !r_push_ok;
                ur_evt    = tx_pop && txq.size() == 0 && framed_mode;
                if (t_pop_ok)  void'(txq.pop_front());
                if (r_pop_ok)  void'(rxq.pop_front());
                if (t_push_ok) txq.push_back(tx_push_data & mmask(m_ws));
                if (r_push_ok) rxq.push_back(rx_push_data & mmask(m_ws));
            end
            if (ovf_evt) m_ovf = 1; else if (err_clr) m_ovf = 0;
            if (ur_evt)  m_ur  = 1; else if (err_clr) m_ur  = 0;
        end
    end

    // Compare every output against the model mid-cycle.
    always @(negedge clk) begin
        int d, tn, rn;
        logic e_tx, e_rx;
        if (live) begin
            d = mdepth(m_ws); tn = txq.size(); rn = rxq.size();
            chk("R10", "tx_level", 32'(tx_level), 32'(tn));
            chk("R10", "rx_level", 32'(rx_level), 32'(rn));
            if (tn > 0) chk("R2", "tx_pop_data", tx_pop_data, txq[0]);
            if (rn > 0) chk("R2", "rx_pop_data", rx_pop_data, rxq[0]);
            chk("R3", "rx_overflow", 32'(rx_overflow), 32'(m_ovf));
            chk("R5", "tx_underrun", 32'(tx_underrun), 32'(m_ur));
            case (rx_irq_mode)
                2'd0: e_rx = (rn == 0);
                2'd1: e_rx = (rn != 0);
                2'd2: e_rx = (2 * rn >= d);
                default: e_rx = (rn == d);
            endcase
            case (tx_irq_mode)
                2'd0: e_tx = (tn == 0) && !tx_shift_busy;
                2'd1: e_tx = (tn == 0);
                2'd2: e_tx = (2 * (d - tn) >= d);
                default: e_tx = (tn < d);
            endcase
            chk("R8", "rx_irq", 32'(rx_irq), 32'(e_rx));
            chk("R9", "tx_irq", 32'(tx_irq), 32'(e_tx));
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle_inputs();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; err_clr = 0;
    endtask

    task automatic at_mid();
        @(negedge clk);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; word_size = 0; framed_mode = 0; tx_shift_busy = 0;
        tx_irq_mode = 0; rx_irq_mode = 0; tx_push_data = 0; rx_push_data = 0;
        idle_inputs();
        repeat (3) tick();
        at_mid();
        chk("R11", "reset tx_level", 32'(tx_level), 0);
        chk("R11", "reset rx_level", 32'(rx_level), 0);
        chk("R11", "reset flags", {30'd0, rx_overflow, tx_underrun}, 0);
        rst_n = 1;
        tick();

        // R1/R3: overfill receive at 8-bit, then drain in order.
        rx_push = 1;
        for (int i = 0; i < 20; i++) begin
            rx_push_data = 32'hA5A5_0000 + 32'(i * 17); tick();
        end
        rx_push = 0; rx_irq_mode = 3; tick(); at_mid();
        chk("R1", "rx depth 8-bit", 32'(rx_level), 16);
        chk("R3", "rx_overflow after overfill", 32'(rx_overflow), 1);
        chk("R8", "rx_irq full", 32'(rx_irq), 1);
        // R10: push and pop together while full.
        rx_push = 1; rx_pop = 1; rx_push_data = 32'h77; tick();
        rx_push = 0; at_mid();
        chk("R10", "full push+pop level", 32'(rx_level), 16);
        repeat (18) tick();
        rx_pop = 0; at_mid();
        chk("R4", "rx pop on empty", 32'(rx_level), 0);

        // R1/R7: word size changes with data held.
        word_size = 1; tick();
        tx_push = 1;
        for (int i = 0; i < 10; i++) begin
            tx_push_data = 32'h1234_5678 + 32'(i); tick();
        end
        tx_push = 0; at_mid();
        chk("R1", "tx depth 16-bit", 32'(tx_level), 8);
        word_size = 2; tx_push = 1; tick(); tx_push = 0; at_mid();
        chk("R7", "flush on size change", 32'(tx_level), 0);
        tx_push = 1;
        for (int i = 0; i < 6; i++) begin
            tx_push_data = 32'hDEAD_BEE0 + 32'(i); tick();
        end
        tx_push = 0; at_mid();
        chk("R1", "tx depth 32-bit", 32'(tx_level), 4);
        word_size = 3; tick(); at_mid();
        chk("R7", "flush on code 3", 32'(tx_level), 0);

        // R5: underrun only when framed.
        tx_pop = 1; framed_mode = 0; tick(); tx_pop = 0; at_mid();
        chk("R5", "unframed empty pop", 32'(tx_underrun), 0);
        chk("R4", "tx pop on empty", 32'(tx_level), 0);
        tx_pop = 1; framed_mode = 1; tick(); tx_pop = 0; at_mid();
        chk("R5", "framed empty pop", 32'(tx_underrun), 1);

        // R6: clear, then event coinciding with clear.
        err_clr = 1; tick(); err_clr = 0; at_mid();
        chk("R6", "clear flags", {30'd0, rx_overflow, tx_underrun}, 0);
        rx_push = 1; repeat (4) tick();
        err_clr = 1; tick(); rx_push = 0; err_clr = 0; at_mid();
        chk("R6", "set wins over clear", 32'(rx_overflow), 1);
        framed_mode = 0;

        // Random traffic across sizes and interrupt modes.
        for (int blk = 0; blk < 8; blk++) begin
            word_size   = 2'($urandom_range(0, 3));
            tx_irq_mode = 2'(blk % 4);
            rx_irq_mode = 2'((blk + 1) % 4);
            for (int c = 0; c < 400; c++) begin
                tx_push       = ($urandom_range(0, 99) < 45 + 10 * (blk % 3));
                tx_pop        = ($urandom_range(0, 99) < 45);
                rx_push       = ($urandom_range(0, 99) < 50);
                rx_pop        = ($urandom_range(0, 99) < 40 + 10 * (blk % 3));
                tx_push_data  = $urandom;
                rx_push_data  = $urandom;
                tx_shift_busy = $urandom_range(0, 1) == 1;
                framed_mode   = $urandom_range(0, 3) == 0;
                err_clr       = $urandom_range(0, 31) == 0;
                tick();
            end
        end
        idle_inputs();
        tick(); at_mid();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule